// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is a 32-bit combinational arithmetic-logic unit with its operation decoder. Main control supplies a 2-bit operation class. For memory address generation the class forces an addition. For equality branches it forces a subtraction. For register-to-register arithmetic the class passes selection to the 6-bit function field of the instruction. That field is the low six bits of the instruction word, bits [5:0].

The decoder turns class and function field into a 3-bit operation code, which is also driven out. The top bit of the code makes the adder compute `A + ~B + 1`. Subtract and signed set-less-than therefore share one carry chain. The datapath returns the 32-bit result and a zero flag, which a branch unit uses to test two operands for equality.

Top module: `alu_top`

## Requirements
- R1: With operation class 2'b00 the operation code is 3'b010 (add) and the result is A + B modulo 2^32, whatever the function field holds.
- R2: With operation class 2'b01 the operation code is 3'b110 (subtract) and the result is A - B modulo 2^32, whatever the function field holds.
- R3: With operation class 2'b11 the function field selects the code: 6'b100000 gives 3'b010 (add), 6'b100010 gives 3'b110 (subtract), 6'b100100 gives 3'b000 (AND), 6'b100101 gives 3'b001 (OR), 6'b101010 gives 3'b111 (set-less-than).
- R4: With operation class 2'b11, any function field value not listed in R3 gives code 3'b010 and the sum A + B.
- R5: Operation class 2'b10 decodes the function field exactly as class 2'b11 does.
- R6: Code 3'b000 returns the bitwise AND of A and B, and code 3'b001 returns their bitwise OR.
- R7: Code 3'b111 returns 32'd1 when A is less than B as two's-complement values and 32'd0 otherwise. This holds also when A - B overflows.
- R8: The zero output is 1 exactly when all 32 result bits are 0. Under class 2'b01 it is therefore 1 exactly when A equals B.
- R9: Add and subtract wrap silently modulo 2^32 and raise no other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opClass | input | 2 | Operation class from main control |
| funct | input | 6 | Function field, instruction bits [5:0] |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| aluCode | output | 3 | Decoded ALU operation code |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |

## Verification
Every output is a pure combinational function of the present inputs. Each result is due in the same cycle its stimulus is applied, with no register on the path. The bench changes the inputs just after a rising edge and compares code, result and zero flag at the following falling edge, half a period later, when the logic has settled. A behavioural model in the bench uses signed integer compares and native addition. It produces the expected values for directed corner cases and a long run of random operands across all classes and function codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    CODE_AND = 3'b000,
    CODE_OR  = 3'b001,
    CODE_ADD = 3'b010,
    CODE_SUB = 3'b110,
    CODE_SLT = 3'b111
  } aluCode_e;

  typedef enum logic [1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_ARITHA = 2'b10,
    CLS_ARITHB = 2'b11
  } opClass_e;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  // Strobes from decoder to datapath.
  // resultSel: 00 and, 01 or, 10 sum, 11 less-than.
  typedef struct packed {
    logic       negateB;
    logic [1:0] resultSel;
  } aluStrobe_t;

endpackage

// File: rtl/alu_decoder.sv
module alu_decoder
  import alu_pkg::*;
(
  input  logic [1:0] opClass,
  input  logic [5:0] funct,
  output logic [2:0] aluCode,
  output aluStrobe_t strobe
);

  aluCode_e fnCode;
  aluCode_e selCode;

  // Second level: function field, only consulted for arithmetic classes
  always_comb begin
    unique case (funct)
      FN_ADD:  fnCode = CODE_ADD;
      FN_SUB:  fnCode = CODE_SUB;
      FN_AND:  fnCode = CODE_AND;
      FN_OR:   fnCode = CODE_OR;
      FN_SLT:  fnCode = CODE_SLT;
      default: fnCode = CODE_ADD;
    endcase
  end

  // First level: coarse class from main control
  always_comb begin
    unique case (opClass)
      CLS_MEM:    selCode = CODE_ADD;
      CLS_BRANCH: selCode = CODE_SUB;
      default:    selCode = fnCode;
    endcase
  end

  assign aluCode          = selCode;
  assign strobe.negateB   = selCode[2];
  assign strobe.resultSel = selCode[1:0];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter bit USE_RIPPLE = 1'b0
) (
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sum;
  logic             overflow;
  logic             lessThan;

  assign bEff = strobe.negateB ? ~opB : opB;

  generate
    if (USE_RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] carry;
      assign carry[0] = strobe.negateB;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i] = opA[i] ^ bEff[i] ^ carry[i];
        if (i < MSB) begin : g_cy
          assign carry[i+1] = (opA[i] & bEff[i]) | (carry[i] & (opA[i] ^ bEff[i]));
        end
      end
    end else begin : g_native
      assign sum = opA + bEff + WIDTH'(strobe.negateB);
    end
  endgenerate

  // Signed overflow: operands agree in sign, sum disagrees
  assign overflow = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
  assign lessThan = sum[MSB] ^ overflow;

  always_comb begin
    unique case (strobe.resultSel)
      2'b00:   result = opA & opB;
      2'b01:   result = opA | opB;
      2'b10:   result = sum;
      default: result = {{(WIDTH-1){1'b0}}, lessThan};
    endcase
  end

  assign zero = ~|result;

endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter bit USE_RIPPLE = 1'b0
) (
  input  logic [1:0]       opClass,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [2:0]       aluCode,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  aluStrobe_t strobe;

  alu_decoder u_decoder (
    .opClass (opClass),
    .funct   (funct),
    .aluCode (aluCode),
    .strobe  (strobe)
  );

  alu_datapath #(
    .WIDTH      (WIDTH),
    .USE_RIPPLE (USE_RIPPLE)
  ) u_datapath (
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .zero   (zero)
  );

endmodule

// File: rtl/alu_top_chk.sv
module alu_top_chk #(
  parameter int WIDTH = 32
) (
  input logic [1:0]       opClass,
  input logic [5:0]       funct,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       aluCode,
  input logic [WIDTH-1:0] result,
  input logic             zero
);

  always_comb begin
    if (opClass == 2'b00) begin
      // R1
      mem_add_chk: assert (aluCode == 3'b010 && result == opA + opB);
    end
    if (opClass == 2'b01) begin
      // R2
      branch_sub_chk: assert (aluCode == 3'b110 && result == opA - opB);
      // R8
      branch_zero_chk: assert (zero == (opA == opB));
    end
    if (opClass[1] && funct == 6'b101010) begin
      // R7
      slt_value_chk: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))});
    end
    if (aluCode == 3'b000) begin
      // R6
      and_value_chk: assert (result == (opA & opB));
    end
    if (aluCode == 3'b001) begin
      // R6
      or_value_chk: assert (result == (opA | opB));
    end
    if (opClass[1] && funct == 6'b100100) begin
      // R3
      fn_and_code_chk: assert (aluCode == 3'b000);
    end
  end

endmodule

bind alu_top alu_top_chk #(.WIDTH(WIDTH)) chk_i (
  .opClass (opClass),
  .funct   (funct),
  .opA     (opA),
  .opB     (opB),
  .aluCode (aluCode),
  .result  (result),
  .zero    (zero)
);

// File: tb/alu_top_tb_top.sv
module alu_top_tb_top;

  logic        clk = 1'b0;
  logic [1:0]  opClass;
  logic [5:0]  funct;
  logic [31:0] opA;
  logic [31:0] opB;
  logic [2:0]  aluCode;
  logic [31:0] result;
  logic        zero;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  alu_top dut_i (
    .opClass (opClass),
    .funct   (funct),
    .opA     (opA),
    .opB     (opB),
    .aluCode (aluCode),
    .result  (result),
    .zero    (zero)
  );

  // Behavioural reference
  function automatic logic [2:0] refCode(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 3'b010;
    if (c == 2'b01) return 3'b110;
    case (f)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  function automatic logic [31:0] refResult(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
    longint sa = $signed(a);
    longint sb = $signed(b);
    case (k)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b110:  return 32'(sa - sb);
      3'b111:  return (sa < sb) ? 32'd1 : 32'd0;
      default: return 32'(sa + sb);
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b);
    logic [2:0]  eCode;
    logic [31:0] eRes;
    logic        eZero;
    @(posedge clk);
    #1;
    opClass = c; funct = f; opA = a; opB = b;
    eCode = refCode(c, f);
    eRes  = refResult(eCode, a, b);
    eZero = (eRes == 32'd0);
    @(negedge clk);
    compared++;
    if (aluCode !== eCode || result !== eRes || zero !== eZero) begin
      mismatched++;
      $display("FAIL %s: code=%b result=%h zero=%b expected code=%b result=%h zero=%b",
               tag, aluCode, result, zero, eCode, eRes, eZero);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end

  initial begin
    opClass = 2'b00; funct = 6'd0; opA = 32'd0; opB = 32'd0;
    // Idle state: add of zeros gives zero flag (R8)
    check("R8", 2'b00, 6'd0, 32'd0, 32'd0);
    // R1: class forces add regardless of funct
    check("R1", 2'b00, 6'b100010, 32'd100, 32'd23);
    check("R1", 2'b00, 6'b101010, 32'h7fff_fff0, 32'h20);
    // R2: class forces subtract
    check("R2", 2'b01, 6'b100100, 32'd50, 32'd70);
    check("R2", 2'b01, 6'b100000, 32'hdead_beef, 32'hdead_beef);
    // R3: each function code
    check("R3", 2'b11, 6'b100000, 32'd7, 32'd9);
    check("R3", 2'b11, 6'b100010, 32'd7, 32'd9);
    check("R3", 2'b11, 6'b100100, 32'hf0f0_ff00, 32'h0ff0_f0f0);
    check("R3", 2'b11, 6'b100101, 32'hf0f0_0000, 32'h0000_0f0f);
    check("R3", 2'b11, 6'b101010, 32'd3, 32'd4);
    // R4: unlisted function codes fall back to add
    check("R4", 2'b11, 6'b000000, 32'd11, 32'd31);
    check("R4", 2'b11, 6'b111111, 32'hffff_ffff, 32'd2);
    check("R4", 2'b11, 6'b100011, 32'd5, 32'd5);
    // R5: class 10 mirrors class 11
    check("R5", 2'b10, 6'b100010, 32'd1, 32'd1);
    check("R5", 2'b10, 6'b101010, 32'hffff_fffe, 32'd1);
    check("R5", 2'b10, 6'b010101, 32'd8, 32'd8);
    // R6: logic ops, including results that are zero
    check("R6", 2'b11, 6'b100100, 32'haaaa_aaaa, 32'h5555_5555);
    check("R6", 2'b11, 6'b100101, 32'd0, 32'd0);
    // R7: signed compare, with overflowing difference
    check("R7", 2'b11, 6'b101010, 32'h8000_0000, 32'h7fff_ffff);
    check("R7", 2'b11, 6'b101010, 32'h7fff_ffff, 32'h8000_0000);
    check("R7", 2'b11, 6'b101010, 32'hffff_ffff, 32'd0);
    check("R7", 2'b11, 6'b101010, 32'd5, 32'd5);
    // R8: equal operands on branch give zero; unequal do not
    check("R8", 2'b01, 6'd0, 32'h1234_5678, 32'h1234_5678);
    check("R8", 2'b01, 6'd0, 32'h1234_5678, 32'h1234_5679);
    // R9: wraparound
    check("R9", 2'b00, 6'd0, 32'hffff_ffff, 32'd1);
    check("R9", 2'b01, 6'd0, 32'd0, 32'd1);
    check("R9", 2'b11, 6'b100000, 32'h8000_0000, 32'h8000_0000);
    // Random sweep across classes and codes
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] fr;
      logic [31:0] ar;
      logic [31:0] br;
      case ($urandom_range(0, 5))
        0: fr = 6'b100000;
        1: fr = 6'b100010;
        2: fr = 6'b100100;
        3: fr = 6'b100101;
        4: fr = 6'b101010;
        default: fr = 6'($urandom);
      endcase
      ar = $urandom;
      br = ($urandom_range(0, 7) == 0) ? ar : 32'($urandom);
      check("R9", 2'($urandom), fr, ar, br);
    end
    finish();
  end

endmodule